// File: doc/BRIEF.md
# Nth-Chance Clock Frame Replacer

This block picks which physical frame to give up when a page fault needs room. The frames sit on a ring with one hand. When a fault arrives, the hand steps around the ring and examines one frame per clock cycle. A frame whose use bit is set loses that bit and is skipped. A frame whose use bit is clear has its sweep count raised. When the count reaches that frame's limit, the frame is chosen. Clean frames have a limit of one pass and modified frames have a limit of two. A modified frame asks for its write-back one pass before it can be taken, so the copy to disk can overlap the rest of the sweep.

Surrounding logic reports every access with the frame index and whether the access was a write. It raises a one-cycle fault request when it needs a frame, and gets back a one-cycle victim pulse carrying the index and the modified flag. After it has fetched the new page, it reports the refill with a load pulse. Until every frame has been loaded once, a fault takes the lowest empty frame at once and the hand does not move.

Top module: `clock_nchance_replacer`

## Requirements
- R1: After reset every frame is empty, the hand points at frame 0, and `victim_valid` and `wb_req` are low.
- R2: While any frame is empty, a fault is answered on the next cycle with the lowest-numbered empty frame and `victim_dirty` = 0, without moving the hand.
- R3: An access to a loaded frame sets its use bit, and an access with `acc_write` = 1 also sets its modified bit.
- R4: The hand examines exactly one frame per cycle while sweeping and moves to the next index, wrapping from the last frame to frame 0. A frame found with its use bit set has that bit and its sweep count cleared and is passed over.
- R5: A clean frame with its use bit clear has its sweep count raised and is chosen when the count reaches CLEAN_CHANCES (default 1).
- R6: A modified frame with its use bit clear raises `wb_req` for one cycle, with its index on `wb_idx`, when its count reaches DIRTY_CHANCES-1 (default 1). It is chosen when the count reaches DIRTY_CHANCES (default 2), with `victim_dirty` = 1.
- R7: `victim_valid` is a one-cycle pulse, registered at the check that makes the choice. The hand then points at the frame after the victim, so a second fault with no refill starts its search past the victim.
- R8: A load marks the frame as filled, with its use bit, modified bit and count all clear. A load takes priority over an access to the same frame in the same cycle.
- R9: A sweep takes at most CLEAN_CHANCES*F+1 checks when no frame is modified, and at most DIRTY_CHANCES*F+1 checks otherwise (F = NUM_FRAMES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | A frame was referenced this cycle |
| acc_idx | input | IDX_W | Index of the referenced frame |
| acc_write | input | 1 | The reference modified the frame |
| load_valid | input | 1 | A frame has just been refilled |
| load_idx | input | IDX_W | Index of the refilled frame |
| fault_req | input | 1 | Request for a victim; accepted only while idle |
| victim_valid | output | 1 | One-cycle pulse: victim chosen |
| victim_idx | output | IDX_W | Index of the chosen frame |
| victim_dirty | output | 1 | The chosen frame holds modified data |
| wb_req | output | 1 | One-cycle pulse: start the early write-back of a modified frame |
| wb_idx | output | IDX_W | Frame to write back |

## Verification
The bench goes after the longest sweeps. With every frame modified and recently used, the hand needs two full laps and then one more check. A design that counted passes wrongly would pick a frame a lap early, or would never stop. Each modified frame must request its write-back exactly once and in ring order. If that were broken, pulses would be missing or repeated, or a frame would be taken before its write-back was requested. A load in the same cycle as a write to the same frame must leave the frame clean and unused. If the access won instead, the frame would be skipped, or it would be reported as modified when it is chosen. Empty frames must be handed out in index order and must not move the hand. If the hand moved, the first real sweep would start at the wrong frame.

// File: rtl/clkrep_pkg.sv
// Shared types for the clock frame replacer.
// Assumes: consumers import this package before declaring ports.
package clkrep_pkg;

    // Sweep controller state
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } sweep_state_e;

    // Action the controller applies to the frame under the hand
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_BUMP  = 2'd2,
        ACT_EVICT = 2'd3
    } chk_act_e;

endpackage

// File: rtl/frame_table.sv
// Per-frame state: present, use, modified and sweep count.
// Assumes: one check action per cycle, on frame chk_idx. A load overrides
// everything else for its frame. An access is applied after the check, so a
// use bit set in the same cycle survives the clear.
module frame_table
    import clkrep_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int IDX_W      = 2,
    parameter int CNT_W      = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic [IDX_W-1:0]            acc_idx,
    input  logic                        acc_write,
    input  logic                        load_valid,
    input  logic [IDX_W-1:0]            load_idx,
    input  chk_act_e                    chk_act,
    input  logic [IDX_W-1:0]            chk_idx,
    output logic [NUM_FRAMES-1:0]       present_vec,
    output logic [NUM_FRAMES-1:0]       use_vec,
    output logic [NUM_FRAMES-1:0]       dirty_vec,
    output logic [NUM_FRAMES*CNT_W-1:0] cnt_flat
);

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        logic             present_q;
        logic             use_q;
        logic             dirty_q;
        logic [CNT_W-1:0] cnt_q;
        logic             load_hit;
        logic             chk_hit;
        logic             acc_hit;

        assign load_hit = load_valid && (load_idx == IDX_W'(g));
        assign chk_hit  = (chk_idx == IDX_W'(g));
        assign acc_hit  = acc_valid && (acc_idx == IDX_W'(g)) && present_q;

        // Update one frame from load, check and access, in that priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                present_q <= 1'b0;
                use_q     <= 1'b0;
                dirty_q   <= 1'b0;
                cnt_q     <= '0;
            end else if (load_hit) begin
                present_q <= 1'b1;
                use_q     <= 1'b0;
                dirty_q   <= 1'b0;
                cnt_q     <= '0;
            end else begin
                if (chk_hit) begin
                    case (chk_act)
                        ACT_CLEAR: begin
                            use_q <= 1'b0;
                            cnt_q <= '0;
                        end
                        ACT_BUMP:  cnt_q <= cnt_q + 1'b1;
                        ACT_EVICT: cnt_q <= '0;
                        default:   ;
                    endcase
                end
                if (acc_hit) begin
                    use_q <= 1'b1;
                    if (acc_write) dirty_q <= 1'b1;
                end
            end
        end

        assign present_vec[g]              = present_q;
        assign use_vec[g]                  = use_q;
        assign dirty_vec[g]                = dirty_q;
        assign cnt_flat[g*CNT_W +: CNT_W]  = cnt_q;
    end

    AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> (present_vec[$past(load_idx)] && !use_vec[$past(load_idx)]
                        && !dirty_vec[$past(load_idx)]
                        && (cnt_flat[$past(load_idx)*CNT_W +: CNT_W] == '0))); // R8

    AST_ACC_SETS_USE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && present_vec[acc_idx] && !(load_valid && load_idx == acc_idx))
        |=> use_vec[$past(acc_idx)]); // R3

endmodule

// File: rtl/empty_pick.sv
// Finds the lowest-numbered frame that has never been loaded.
// Assumes: present_vec comes straight from the frame table.
module empty_pick #(
    parameter int NUM_FRAMES = 4,
    parameter int IDX_W      = 2
) (
    input  logic [NUM_FRAMES-1:0] present_vec,
    output logic                  any_empty,
    output logic [IDX_W-1:0]      empty_idx
);

    // Priority encode from the top so the lowest empty index wins
    always_comb begin
        any_empty = 1'b0;
        empty_idx = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (!present_vec[i]) begin
                any_empty = 1'b1;
                empty_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/sweep_ctrl.sv
// Clock hand and sweep state machine. It decides each check, raises the
// early write-back and the victim pulse, and answers from the empty-frame
// finder while frames are still empty.
// Assumes: every frame is present whenever a sweep runs. A fault raised
// during a sweep is ignored.
module sweep_ctrl
    import clkrep_pkg::*;
#(
    parameter int NUM_FRAMES     = 4,
    parameter int IDX_W          = 2,
    parameter int CNT_W          = 2,
    parameter int CLEAN_CHANCES  = 1,
    parameter int DIRTY_CHANCES  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fault_req,
    input  logic                        any_empty,
    input  logic [IDX_W-1:0]            empty_idx,
    input  logic [NUM_FRAMES-1:0]       present_vec,
    input  logic [NUM_FRAMES-1:0]       use_vec,
    input  logic [NUM_FRAMES-1:0]       dirty_vec,
    input  logic [NUM_FRAMES*CNT_W-1:0] cnt_flat,
    output chk_act_e                    chk_act,
    output logic [IDX_W-1:0]            chk_idx,
    output logic                        victim_valid,
    output logic [IDX_W-1:0]            victim_idx,
    output logic                        victim_dirty,
    output logic                        wb_req,
    output logic [IDX_W-1:0]            wb_idx
);

    localparam int MAX_CH    = (DIRTY_CHANCES > CLEAN_CHANCES) ? DIRTY_CHANCES : CLEAN_CHANCES;
    localparam int MAX_CHK   = MAX_CH * NUM_FRAMES + 1;
    localparam int CHK_W     = $clog2(MAX_CHK + 2);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

    sweep_state_e      state_q;
    logic [IDX_W-1:0]  hand_q;
    logic [IDX_W-1:0]  hand_nx;
    logic              vic_q, vic_dirty_q, wb_q;
    logic [IDX_W-1:0]  vic_idx_q, wb_idx_q;
    logic [CHK_W-1:0]  chk_cnt_q;
    logic              cur_use, cur_dirty;
    logic [CNT_W-1:0]  cur_cnt, cnt_next, limit;
    logic              early_wb;

    // Read the frame under the hand and work out its fate
    always_comb begin
        cur_use   = use_vec[hand_q];
        cur_dirty = dirty_vec[hand_q];
        cur_cnt   = cnt_flat[hand_q*CNT_W +: CNT_W];
        cnt_next  = cur_cnt + 1'b1;
        limit     = cur_dirty ? CNT_W'(DIRTY_CHANCES) : CNT_W'(CLEAN_CHANCES);
        early_wb  = 1'b0;
        chk_act   = ACT_NONE;
        if (state_q == ST_SWEEP) begin
            if (cur_use) begin
                chk_act = ACT_CLEAR;
            end else if (cnt_next >= limit) begin
                chk_act = ACT_EVICT;
            end else begin
                chk_act  = ACT_BUMP;
                early_wb = cur_dirty && (DIRTY_CHANCES > 1)
                           && (cnt_next == CNT_W'(DIRTY_CHANCES - 1));
            end
        end
    end

    assign hand_nx = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
    assign chk_idx = hand_q;

    // Sweep state, hand position and the registered result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hand_q      <= '0;
            vic_q       <= 1'b0;
            vic_idx_q   <= '0;
            vic_dirty_q <= 1'b0;
            wb_q        <= 1'b0;
            wb_idx_q    <= '0;
            chk_cnt_q   <= '0;
        end else begin
            vic_q <= 1'b0;
            wb_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    chk_cnt_q <= '0;
                    if (fault_req) begin
                        if (any_empty) begin
                            vic_q       <= 1'b1;
                            vic_idx_q   <= empty_idx;
                            vic_dirty_q <= 1'b0;
                        end else begin
                            state_q <= ST_SWEEP;
                        end
                    end
                end
                ST_SWEEP: begin
                    hand_q    <= hand_nx;
                    chk_cnt_q <= chk_cnt_q + 1'b1;
                    if (early_wb) begin
                        wb_q     <= 1'b1;
                        wb_idx_q <= hand_q;
                    end
                    if (chk_act == ACT_EVICT) begin
                        vic_q       <= 1'b1;
                        vic_idx_q   <= hand_q;
                        vic_dirty_q <= cur_dirty;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign victim_valid = vic_q;
    assign victim_idx   = vic_idx_q;
    assign victim_dirty = vic_dirty_q;
    assign wb_req       = wb_q;
    assign wb_idx       = wb_idx_q;

    AST_HAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |=> (hand_q == (($past(hand_q) == LAST_IDX) ? '0 : $past(hand_q) + 1'b1))); // R4

    AST_VICTIM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |=> !victim_valid); // R7

    AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |-> (chk_cnt_q < CHK_W'(MAX_CHK))); // R9

    AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> dirty_vec[wb_idx]); // R6

    AST_EMPTY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        any_empty |-> !present_vec[empty_idx]); // R2

endmodule

// File: rtl/clock_nchance_replacer.sv
// Top of the clock frame replacer: connects the frame table, the empty
// finder and the sweep controller.
// Assumes: the user loads the victim frame before it raises the next fault.
module clock_nchance_replacer
    import clkrep_pkg::*;
#(
    parameter int NUM_FRAMES    = 4,
    parameter int CLEAN_CHANCES = 1,
    parameter int DIRTY_CHANCES = 2,
    localparam int IDX_W        = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int CNT_W        = $clog2(DIRTY_CHANCES + CLEAN_CHANCES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             acc_write,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             fault_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx,
    output logic             victim_dirty,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx
);

    logic [NUM_FRAMES-1:0]       present_vec, use_vec, dirty_vec;
    logic [NUM_FRAMES*CNT_W-1:0] cnt_flat;
    logic                        any_empty;
    logic [IDX_W-1:0]            empty_idx;
    chk_act_e                    chk_act;
    logic [IDX_W-1:0]            chk_idx;

    frame_table #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_idx     (acc_idx),
        .acc_write   (acc_write),
        .load_valid  (load_valid),
        .load_idx    (load_idx),
        .chk_act     (chk_act),
        .chk_idx     (chk_idx),
        .present_vec (present_vec),
        .use_vec     (use_vec),
        .dirty_vec   (dirty_vec),
        .cnt_flat    (cnt_flat)
    );

    empty_pick #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDX_W      (IDX_W)
    ) u_empty (
        .present_vec (present_vec),
        .any_empty   (any_empty),
        .empty_idx   (empty_idx)
    );

    sweep_ctrl #(
        .NUM_FRAMES    (NUM_FRAMES),
        .IDX_W         (IDX_W),
        .CNT_W         (CNT_W),
        .CLEAN_CHANCES (CLEAN_CHANCES),
        .DIRTY_CHANCES (DIRTY_CHANCES)
    ) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_req    (fault_req),
        .any_empty    (any_empty),
        .empty_idx    (empty_idx),
        .present_vec  (present_vec),
        .use_vec      (use_vec),
        .dirty_vec    (dirty_vec),
        .cnt_flat     (cnt_flat),
        .chk_act      (chk_act),
        .chk_idx      (chk_idx),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx),
        .victim_dirty (victim_dirty),
        .wb_req       (wb_req),
        .wb_idx       (wb_idx)
    );

endmodule

// File: tb/clock_nchance_replacer_tb_top.sv
// Directed bench: one task per scenario, four frames, default chances.
module clock_nchance_replacer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_valid, acc_write, load_valid, fault_req;
    logic [1:0] acc_idx, load_idx;
    logic       victim_valid, victim_dirty, wb_req;
    logic [1:0] victim_idx, wb_idx;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int   wb_cnt;
    int   wb_log [0:15];
    int   lat;

    always #4 clk = ~clk;

    clock_nchance_replacer #(.NUM_FRAMES(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write),
        .load_valid(load_valid), .load_idx(load_idx),
        .fault_req(fault_req),
        .victim_valid(victim_valid), .victim_idx(victim_idx),
        .victim_dirty(victim_dirty), .wb_req(wb_req), .wb_idx(wb_idx)
    );

    task automatic check_eq(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_idx = 0;
        load_valid = 0; load_idx = 0; fault_req = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic access(int idx, bit wr);
        @(negedge clk);
        acc_valid = 1; acc_idx = 2'(idx); acc_write = wr;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic load(int idx);
        @(negedge clk);
        load_valid = 1; load_idx = 2'(idx);
        @(negedge clk);
        load_valid = 0;
    endtask

    // Raise a fault, then count cycles to the victim and log write-backs
    task automatic fault_watch();
        @(negedge clk);
        fault_req = 1;
        @(negedge clk);
        fault_req = 0;
        lat = 0; wb_cnt = 0;
        while (!victim_valid && lat < 40) begin
            if (wb_req) begin
                wb_log[wb_cnt] = int'(wb_idx);
                wb_cnt++;
            end
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic fill_all();
        for (int i = 0; i < 4; i++) begin
            fault_watch();
            check_eq("R2 fill victim index", int'(victim_idx), i);
            check_eq("R2 fill latency", lat, 0);
            load(i);
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check_eq("R1 victim_valid after reset", int'(victim_valid), 0);
        check_eq("R1 wb_req after reset", int'(wb_req), 0);
        fault_watch();
        check_eq("R1 first fault gets frame 0", int'(victim_idx), 0);
    endtask

    task automatic t_empty_order();
        do_reset();
        access(2, 1'b1);           // access to an empty frame
        fault_watch();
        check_eq("R2 lowest empty", int'(victim_idx), 0);
        check_eq("R2 empty not dirty", int'(victim_dirty), 0);
        load(0);
        fault_watch();
        check_eq("R2 next empty", int'(victim_idx), 1);
        fault_watch();
        check_eq("R2 unloaded frame offered again", int'(victim_idx), 1);
        check_eq("R2 latency", lat, 0);
    endtask

    task automatic t_clean_first();
        do_reset();
        fill_all();
        fault_watch();
        check_eq("R5 clean victim", int'(victim_idx), 0);
        check_eq("R5 one check", lat, 1);
        check_eq("R5 no writeback", wb_cnt, 0);
        check_eq("R5 clean flag", int'(victim_dirty), 0);
        @(negedge clk);
        check_eq("R7 pulse is one cycle", int'(victim_valid), 0);
    endtask

    task automatic t_second_chance();
        do_reset();
        fill_all();
        access(0, 1'b0);
        fault_watch();
        check_eq("R4 used frame skipped", int'(victim_idx), 1);
        check_eq("R4 two checks", lat, 2);
        fault_watch();
        check_eq("R7 hand past victim", int'(victim_idx), 2);
        check_eq("R7 one check", lat, 1);
    endtask

    task automatic t_dirty_bound();
        do_reset();
        fill_all();
        for (int i = 0; i < 4; i++) access(i, 1'b1);
        fault_watch();
        check_eq("R9 dirty worst case checks", lat, 9);
        check_eq("R6 dirty victim", int'(victim_idx), 0);
        check_eq("R6 dirty flag", int'(victim_dirty), 1);
        check_eq("R6 writeback count", wb_cnt, 4);
        for (int i = 0; i < 4; i++)
            check_eq("R6 writeback order", (i < wb_cnt) ? wb_log[i] : -1, i);
        load(0);
        fault_watch();
        check_eq("R6 second-pass dirty victim", int'(victim_idx), 1);
        check_eq("R6 second-pass latency", lat, 1);
        check_eq("R6 no repeated writeback", wb_cnt, 0);
        check_eq("R3 write marks dirty", int'(victim_dirty), 1);
    endtask

    task automatic t_clean_bound();
        do_reset();
        fill_all();
        for (int i = 0; i < 4; i++) access(i, 1'b0);
        fault_watch();
        check_eq("R9 clean worst case checks", lat, 5);
        check_eq("R9 clean wrap victim", int'(victim_idx), 0);
        check_eq("R9 clean no writeback", wb_cnt, 0);
    endtask

    task automatic t_load_wins();
        do_reset();
        fill_all();
        access(0, 1'b0);
        access(1, 1'b0);
        @(negedge clk);
        load_valid = 1; load_idx = 2; acc_valid = 1; acc_idx = 2; acc_write = 1;
        @(negedge clk);
        load_valid = 0; acc_valid = 0; acc_write = 0;
        fault_watch();
        check_eq("R8 reloaded frame chosen", int'(victim_idx), 2);
        check_eq("R8 reloaded frame clean", int'(victim_dirty), 0);
        check_eq("R8 latency", lat, 3);
    endtask

    initial begin
        t_reset();
        t_empty_order();
        t_clean_first();
        t_second_chance();
        t_dirty_bound();
        t_clean_bound();
        t_load_wins();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule